// File: doc/BRIEF.md
# Dual-Port LUT Distributed RAM

A small 64-bit memory assembled from 16-word by 1-bit storage cells. It has one read/write port and one independent read-only port. A write takes effect on the rising clock edge while the write enable is high. Both ports read combinationally, so the read/write port shows the old word at the written address until that edge. Every bit position is stored twice with the same write data. One copy is read at the write address and the other at the read-only address, so the two ports never compete for a cell.

The parameter `DEPTH` sets the shape of the memory: 16 words of 4 bits, 32 of 2 or 64 of 1. Address bits above bit 3 select a group of cells. On a write they gate the write enable to that group only; on a read they steer a selection mux. Each port can be passed through an output register that shares the write clock, has its own clock enable and is cleared by a synchronous reset. The register can also be bypassed. The stored words power up as zero and are never cleared by reset.

Top module: `lutram_dp`

## Requirements
- R1: A word is stored only at a rising clock edge with `wr_en` = 1, at `wr_addr`. A cycle with `wr_en` = 0 changes no stored word.
- R2: With the primary register bypassed (`REG_PRIMARY` = 0), `pri_q` equals the word at `wr_addr` combinationally. During a write cycle it shows the old word until the edge and the new word after it.
- R3: The secondary port returns the word at `rd_addr`, including words written through the primary port. When `rd_addr` = `wr_addr` it returns the same value the primary port shows.
- R4: `WIDTH` = 64/`DEPTH` for `DEPTH` of 16, 32 or 64. Address bits `[ADDR_W-1:4]` choose the cell group, so writes to addresses that share bits `[3:0]` but differ in upper bits do not disturb each other.
- R5: With `REG_SECONDARY` = 1, at each rising edge with `sec_ce` = 1, `sec_q` loads the word at `rd_addr` as it was before that edge. When `sec_ce` = 0, `sec_q` holds its value.
- R6: The output register clock enables do not gate writing. A write with `sec_ce` = 0 still stores its word.
- R7: A rising edge with `rst` = 1 clears every enabled output register to zero, taking priority over its clock enable. Stored words are kept.
- R8: All stored words are zero before the first write.
- R9: A write and a secondary read at the same address in the same cycle give the secondary port the old word at that edge and the new word from the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, also clocks the output registers |
| rst | input | 1 | Synchronous active-high clear of the output registers |
| wr_en | input | 1 | Active-high write enable |
| wr_addr | input | ADDR_W | Read/write port address |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | ADDR_W | Read-only port address |
| pri_ce | input | 1 | Clock enable of the primary output register |
| sec_ce | input | 1 | Clock enable of the secondary output register |
| pri_q | output | WIDTH | Primary read data |
| sec_q | output | WIDTH | Secondary read data |

## Verification
The bench runs the default shape of 32 words by 2 bits, with the primary port bypassed and the secondary port registered. With the primary port bypassed, its result is due in the same cycle as the address, so the bench samples it 1 ns after driving at the falling edge, which is before the write edge and gives the old word. It samples again 1 ns after the rising edge to see the new word. The registered secondary result is due one rising edge after its address and enable are applied, so the bench records the expected word from its reference array before it applies that edge's write and compares just after the edge. The bench sweeps every address with several data patterns, with offset and colliding read addresses, with the enable low and with reset.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
  localparam int CELL_WORDS = 16;
  localparam int CELL_AW    = 4;
  localparam int TOTAL_BITS = 64;

  function automatic int width_for(input int depth);
    return TOTAL_BITS / depth;
  endfunction
endpackage

// File: rtl/lutram_cell16.sv
module lutram_cell16 (
  input  logic       clk,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic       wr_bit,
  input  logic [3:0] rd_addr,
  output logic       rd_bit
);
  logic [15:0] bits = '0;

  always_ff @(posedge clk) begin
    if (wr_en) bits[wr_addr] <= wr_bit;
  end

  assign rd_bit = bits[rd_addr];
endmodule

// File: rtl/lutram_bank.sv
module lutram_bank #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [3:0]       rd_addr,
  output logic [WIDTH-1:0] pri_bits,
  output logic [WIDTH-1:0] sec_bits
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // copy read at the write address
    lutram_cell16 pri_cell_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_bit  (wr_data[i]),
      .rd_addr (wr_addr),
      .rd_bit  (pri_bits[i])
    );
    // copy read at the independent address
    lutram_cell16 sec_cell_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_bit  (wr_data[i]),
      .rd_addr (rd_addr),
      .rd_bit  (sec_bits[i])
    );
  end
endmodule

// File: rtl/lutram_rd_mux.sv
module lutram_rd_mux #(
  parameter int WIDTH = 2,
  parameter int BANKS = 2,
  parameter int SEL_W = 1
) (
  input  logic [BANKS*WIDTH-1:0] bank_data,
  input  logic [SEL_W-1:0]       sel,
  output logic [WIDTH-1:0]       dout
);
  if (BANKS == 1) begin : g_single
    logic unused_sel;
    assign unused_sel = ^sel;
    assign dout = bank_data;
  end else begin : g_tree
    assign dout = bank_data[sel*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/lutram_out_reg.sv
module lutram_out_reg #(
  parameter int WIDTH  = 2,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  if (ENABLE) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ce) q <= d;
    end
  end else begin : g_bypass
    logic unused_ctl;
    assign unused_ctl = clk ^ rst ^ ce;
    assign q = d;
  end
endmodule

// File: rtl/lutram_dp.sv
module lutram_dp
  import lutram_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter bit REG_PRIMARY   = 1'b0,
  parameter bit REG_SECONDARY = 1'b1,
  localparam int WIDTH  = width_for(DEPTH),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              pri_ce,
  input  logic              sec_ce,
  output logic [WIDTH-1:0]  pri_q,
  output logic [WIDTH-1:0]  sec_q
);
  localparam int BANKS = DEPTH / CELL_WORDS;
  localparam int SEL_W = (ADDR_W > CELL_AW) ? ADDR_W - CELL_AW : 1;

  logic [SEL_W-1:0]       wr_sel, rd_sel;
  logic [BANKS*WIDTH-1:0] pri_all, sec_all;
  logic [WIDTH-1:0]       pri_comb, sec_comb;

  if (BANKS > 1) begin : g_sel
    assign wr_sel = wr_addr[ADDR_W-1:CELL_AW];
    assign rd_sel = rd_addr[ADDR_W-1:CELL_AW];
  end else begin : g_nosel
    assign wr_sel = '0;
    assign rd_sel = '0;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_sel == SEL_W'(b));
    lutram_bank #(.WIDTH(WIDTH)) bank_i (
      .clk      (clk),
      .wr_en    (bank_we),
      .wr_addr  (wr_addr[CELL_AW-1:0]),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr[CELL_AW-1:0]),
      .pri_bits (pri_all[b*WIDTH +: WIDTH]),
      .sec_bits (sec_all[b*WIDTH +: WIDTH])
    );
  end

  lutram_rd_mux #(.WIDTH(WIDTH), .BANKS(BANKS), .SEL_W(SEL_W)) pri_mux_i (
    .bank_data (pri_all),
    .sel       (wr_sel),
    .dout      (pri_comb)
  );

  lutram_rd_mux #(.WIDTH(WIDTH), .BANKS(BANKS), .SEL_W(SEL_W)) sec_mux_i (
    .bank_data (sec_all),
    .sel       (rd_sel),
    .dout      (sec_comb)
  );

  lutram_out_reg #(.WIDTH(WIDTH), .ENABLE(REG_PRIMARY)) pri_reg_i (
    .clk (clk),
    .rst (rst),
    .ce  (pri_ce),
    .d   (pri_comb),
    .q   (pri_q)
  );

  lutram_out_reg #(.WIDTH(WIDTH), .ENABLE(REG_SECONDARY)) sec_reg_i (
    .clk (clk),
    .rst (rst),
    .ce  (sec_ce),
    .d   (sec_comb),
    .q   (sec_q)
  );
endmodule

// File: rtl/lutram_dp_chk.sv
module lutram_dp_chk #(
  parameter int DEPTH         = 32,
  parameter bit REG_PRIMARY   = 1'b0,
  parameter bit REG_SECONDARY = 1'b1,
  localparam int WIDTH  = 64 / DEPTH,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              pri_ce,
  input logic              sec_ce,
  input logic [WIDTH-1:0]  pri_q,
  input logic [WIDTH-1:0]  sec_q
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  logic unused_in;
  assign unused_in = pri_ce;

  if (!REG_PRIMARY) begin : g_pri
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(wr_en) && (wr_addr == $past(wr_addr)) |-> pri_q == $past(wr_data)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(wr_en) && (wr_addr == $past(wr_addr)) |-> pri_q == $past(pri_q)); // R1
  end

  if (REG_SECONDARY) begin : g_sec
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && !$past(sec_ce) |-> sec_q == $past(sec_q)); // R5
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(rst) |-> sec_q == '0); // R7
    if (!REG_PRIMARY) begin : g_agree
      AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) && $past(sec_ce) && ($past(rd_addr) == $past(wr_addr))
        |-> sec_q == $past(pri_q)); // R3
    end
  end
endmodule

bind lutram_dp lutram_dp_chk #(
  .DEPTH(DEPTH), .REG_PRIMARY(REG_PRIMARY), .REG_SECONDARY(REG_SECONDARY)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .pri_ce(pri_ce), .sec_ce(sec_ce), .pri_q(pri_q), .sec_q(sec_q)
);

// File: tb/lutram_dp_tb.sv
`timescale 1ns/1ps
module lutram_dp_tb_top;
  localparam int DEPTH = 32;
  localparam int WIDTH = 64 / DEPTH;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic pri_ce = 1'b0;
  logic sec_ce = 1'b0;
  logic [WIDTH-1:0] pri_q, sec_q;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] ref_mem [DEPTH];
  logic [WIDTH-1:0] exp_sec = '0;

  always #10 clk = ~clk;

  lutram_dp #(.DEPTH(DEPTH), .REG_PRIMARY(1'b0), .REG_SECONDARY(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pri_ce(pri_ce), .sec_ce(sec_ce), .pri_q(pri_q), .sec_q(sec_q)
  );

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at falling edge, check combinational read, then post-edge results
  task automatic step(input logic we, input int a, input logic [WIDTH-1:0] d,
                      input int ra, input logic ce, input logic rs);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(a); wr_data = d; rd_addr = AW'(ra); sec_ce = ce; rst = rs;
    #1;
    check(we ? "R2 old word before edge" : "R2 combinational read", pri_q, ref_mem[a]);
    @(posedge clk);
    if (rs) exp_sec = '0;
    else if (ce) exp_sec = ref_mem[ra];
    if (we) ref_mem[a] = d;
    #1;
    check(we ? "R1 word stored at edge" : "R1 no write without enable", pri_q, ref_mem[a]);
    check(rs ? "R7 reset clears register" : (ce ? "R5/R3 secondary capture" : "R5 secondary hold"),
          sec_q, exp_sec);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    // R7: reset state of the registered port
    step(1'b0, 0, '0, 0, 1'b1, 1'b1);
    step(1'b0, 0, '0, 0, 1'b1, 1'b1);
    check("R7 reset value", sec_q, '0);
    // R8: everything starts at zero on both ports
    for (int a = 0; a < DEPTH; a++) step(1'b0, a, '1, DEPTH - 1 - a, 1'b1, 1'b0);
    // R1/R4: fill every address, reading an offset address on the secondary port
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, a, WIDTH'(a * 3 + 1), (a + 7) % DEPTH, 1'b1, 1'b0);
    // R4: addresses sharing low bits keep distinct words; read everything back
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, a, '0, a, 1'b1, 1'b0);
      check("R4 group isolation", sec_q, WIDTH'(a * 3 + 1));
    end
    // R1: write enable low with changed data leaves contents
    for (int a = 0; a < DEPTH; a += 5) step(1'b0, a, ~WIDTH'(a * 3 + 1), a, 1'b1, 1'b0);
    // R9/R3: colliding write and secondary read at the same address
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b1, a, WIDTH'(a ^ 2), a, 1'b1, 1'b0);
      step(1'b0, a, '0, a, 1'b1, 1'b0);
      check("R9 new word after collision", sec_q, WIDTH'(a ^ 2));
    end
    // R6: writes with the secondary enable low still land; register holds
    for (int a = 0; a < DEPTH; a++) step(1'b1, a, WIDTH'(~a), (a + 1) % DEPTH, 1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 0, '0, a, 1'b1, 1'b0);
      check("R6 write with enable low stored", sec_q, WIDTH'(~a));
    end
    // R7: mid-run reset overrides enable, keeps contents
    step(1'b0, 3, '0, 9, 1'b1, 1'b1);
    check("R7 reset over enable", sec_q, '0);
    step(1'b0, 3, '0, 9, 1'b1, 1'b0);
    check("R7 contents kept over reset", sec_q, WIDTH'(~9));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule